// File: doc/BRIEF.md
# Timer Compare Toggle Output Channel

This block is one compare channel that watches a free-running 16-bit timebase count. It holds a 16-bit compare value. Each time the count reaches that value, the channel inverts its output level, sets a sticky match flag and, when interrupts are enabled, raises an interrupt request. Software uses it to make edges at exact timebase instants, for example square waves or one-off pulses.

The compare value is loaded through two byte-wide write strobes. A write to the lower byte disarms the comparator. A write to the upper byte arms it again. Software therefore writes the lower byte first, and a compare value that is only half written can never produce a match. Match detection reacts to the first cycle in which the count equals the compare value. A timebase that stops on the match value therefore gives one event, not one per cycle.

Top module: `tct_channel`

## Requirements
- R1: While reset is high, and after it, the output level is low, the match flag is 0, the interrupt request is 0 and the comparator is disarmed (`cmp_armed` = 0), until later inputs change them.
- R2: A lower-byte write (`wr_lo`) loads bits 7:0 of the compare value and sets `cmp_armed` to 0 at the same clock edge. An upper-byte write (`wr_hi`) loads bits 15:8 and sets `cmp_armed` to 1. When both strobes are high in the same cycle, `cmp_armed` ends at 1.
- R3: A match is the first clock edge at which `tb_count` equals the compare value after a cycle in which it did not. When toggle-enable, match-enable and `cmp_armed` are all 1, `tog_out` inverts at that edge.
- R4: If the count stays on the compare value for several cycles, `tog_out` inverts only once.
- R5: While `cmp_armed` is 0, `tog_out` keeps its level and the flag is not set by a match.
- R6: With match-enable 1 and toggle-enable 0, a match sets the flag and leaves `tog_out` unchanged.
- R7: The match flag stays 1 until `flag_clr` is pulsed. `irq` is 1 exactly when the flag is 1 and interrupt-enable is 1.
- R8: If `flag_clr` and a match fall in the same cycle, the flag stays 1.
- R9: A compare-byte write in the same cycle as a match compares against the value held before that write.
- R10: Mode bits are loaded from `mode_tog`, `mode_mat` and `mode_ie` on a `mode_wr` pulse, and hold until the next pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tb_count | input | 16 | Timebase count |
| wr_lo | input | 1 | Strobe that writes the lower compare byte |
| wr_hi | input | 1 | Strobe that writes the upper compare byte |
| wr_data | input | 8 | Byte for the compare-byte writes |
| mode_wr | input | 1 | Strobe that loads the mode bits |
| mode_tog | input | 1 | Toggle-enable value |
| mode_mat | input | 1 | Match-enable value |
| mode_ie | input | 1 | Interrupt-enable value |
| flag_clr | input | 1 | Clears the match flag |
| tog_out | output | 1 | Toggling output level |
| match_flag | output | 1 | Sticky match flag |
| irq | output | 1 | Interrupt request |
| cmp_armed | output | 1 | Comparator armed state |

## Verification
The count is driven through values just below the compare value, onto it, and past it. This separates a true equality match from an off-by-one. A count held on the compare value shows whether the design fires on every cycle of equality or only on the first. Counts that reach the compare value while the comparator is disarmed, while toggle-enable is 0 or while interrupt-enable is 0 each isolate one enable path. Matches that coincide with a flag clear or with a compare-byte write decide which of the two events takes priority.

// File: rtl/tct_pkg.sv
package tct_pkg;

    localparam int unsigned BYTE_W_DEF = 8;
    localparam int unsigned LANES      = 2;

    typedef struct packed {
        logic tog_en;
        logic mat_en;
        logic irq_en;
    } tct_mode_t;

    typedef struct packed {
        logic fire;
        logic flip;
    } tct_evt_t;

    function automatic tct_evt_t tct_decode(input logic hit, input logic armed,
                                            input tct_mode_t mode);
        tct_evt_t e;
        e.fire = hit & armed & mode.mat_en;
        e.flip = e.fire & mode.tog_en;
        return e;
    endfunction

endpackage

// File: rtl/tct_cmp_reg.sv
module tct_cmp_reg #(
    parameter int unsigned BYTE_W = tct_pkg::BYTE_W_DEF,
    localparam int unsigned CNT_W = tct_pkg::LANES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [CNT_W-1:0]  cmp_val,
    output logic              armed
);
    logic [tct_pkg::LANES-1:0] lane_we;
    assign lane_we = {wr_hi, wr_lo};

    for (genvar g = 0; g < tct_pkg::LANES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst)
                cmp_val[g*BYTE_W +: BYTE_W] <= '0;
            else if (lane_we[g])
                cmp_val[g*BYTE_W +: BYTE_W] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        armed <= 1'b0;
        else if (wr_hi) armed <= 1'b1;
        else if (wr_lo) armed <= 1'b0;
    end
endmodule

// File: rtl/tct_match_det.sv
module tct_match_det #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] cmp_val,
    output logic             hit
);
    logic eq_now;
    logic eq_q;

    assign eq_now = (count == cmp_val);

    always_ff @(posedge clk) begin
        if (rst) eq_q <= 1'b1;
        else     eq_q <= eq_now;
    end

    assign hit = eq_now & ~eq_q;
endmodule

// File: rtl/tct_out_ctl.sv
module tct_out_ctl
    import tct_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      hit,
    input  logic      armed,
    input  logic      mode_wr,
    input  tct_mode_t mode_in,
    input  logic      flag_clr,
    output tct_mode_t mode_q,
    output logic      tog_q,
    output logic      flag_q,
    output logic      irq
);
    tct_evt_t evt;
    assign evt = tct_decode(hit, armed, mode_q);

    always_ff @(posedge clk) begin
        if (rst)          mode_q <= '0;
        else if (mode_wr) mode_q <= mode_in;
    end

    always_ff @(posedge clk) begin
        if (rst)           tog_q <= 1'b0;
        else if (evt.flip) tog_q <= ~tog_q;
    end

    always_ff @(posedge clk) begin
        if (rst)           flag_q <= 1'b0;
        else if (evt.fire) flag_q <= 1'b1;
        else if (flag_clr) flag_q <= 1'b0;
    end

    assign irq = flag_q & mode_q.irq_en;
endmodule

// File: rtl/tct_channel.sv
module tct_channel
    import tct_pkg::*;
#(
    parameter int unsigned BYTE_W = BYTE_W_DEF,
    localparam int unsigned CNT_W = LANES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  tb_count,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              mode_wr,
    input  logic              mode_tog,
    input  logic              mode_mat,
    input  logic              mode_ie,
    input  logic              flag_clr,
    output logic              tog_out,
    output logic              match_flag,
    output logic              irq,
    output logic              cmp_armed
);
    logic [CNT_W-1:0] cmp_val;
    logic             hit;
    tct_mode_t        mode_in;
    tct_mode_t        mode_q;

    assign mode_in = '{tog_en: mode_tog, mat_en: mode_mat, irq_en: mode_ie};

    tct_cmp_reg #(.BYTE_W(BYTE_W)) u_cmp (
        .clk(clk), .rst(rst), .wr_lo(wr_lo), .wr_hi(wr_hi),
        .wr_data(wr_data), .cmp_val(cmp_val), .armed(cmp_armed)
    );

    tct_match_det #(.CNT_W(CNT_W)) u_det (
        .clk(clk), .rst(rst), .count(tb_count), .cmp_val(cmp_val), .hit(hit)
    );

    tct_out_ctl u_out (
        .clk(clk), .rst(rst), .hit(hit), .armed(cmp_armed),
        .mode_wr(mode_wr), .mode_in(mode_in), .flag_clr(flag_clr),
        .mode_q(mode_q), .tog_q(tog_out), .flag_q(match_flag), .irq(irq)
    );
endmodule

// File: rtl/tct_channel_chk.sv
module tct_channel_chk #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic [CNT_W-1:0] tb_count,
    input logic [CNT_W-1:0] cmp_val,
    input logic             hit,
    input logic             mat_en,
    input logic             wr_lo,
    input logic             wr_hi,
    input logic             flag_clr,
    input logic             tog_out,
    input logic             match_flag,
    input logic             cmp_armed
);
    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!tog_out && !match_flag && !cmp_armed)); // R1

    AST_LO_DISARMS: assert property (@(posedge clk) disable iff (rst)
        (wr_lo && !wr_hi) |=> !cmp_armed); // R2

    AST_HI_ARMS: assert property (@(posedge clk) disable iff (rst)
        wr_hi |=> cmp_armed); // R2

    AST_STALL_ONCE: assert property (@(posedge clk) disable iff (rst)
        ($stable(tb_count) && $stable(cmp_val)) |=> $stable(tog_out)); // R4

    AST_DISARMED_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cmp_armed |=> $stable(tog_out)); // R5

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (match_flag && !flag_clr) |=> match_flag); // R7

    AST_MATCH_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (flag_clr && hit && cmp_armed && mat_en) |=> match_flag); // R8
endmodule

bind tct_channel tct_channel_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .tb_count(tb_count), .cmp_val(cmp_val),
    .hit(hit), .mat_en(mode_q.mat_en), .wr_lo(wr_lo), .wr_hi(wr_hi),
    .flag_clr(flag_clr), .tog_out(tog_out), .match_flag(match_flag),
    .cmp_armed(cmp_armed)
);

// File: tb/tct_channel_tb.sv
module tct_channel_tb;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] tb_count = '0;
    logic        wr_lo = 1'b0, wr_hi = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        mode_wr = 1'b0, mode_tog = 1'b0, mode_mat = 1'b0, mode_ie = 1'b0;
    logic        flag_clr = 1'b0;
    logic        tog_out, match_flag, irq, cmp_armed;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    tct_channel u_dut (
        .clk(clk), .rst(rst), .tb_count(tb_count), .wr_lo(wr_lo), .wr_hi(wr_hi),
        .wr_data(wr_data), .mode_wr(mode_wr), .mode_tog(mode_tog),
        .mode_mat(mode_mat), .mode_ie(mode_ie), .flag_clr(flag_clr),
        .tog_out(tog_out), .match_flag(match_flag), .irq(irq), .cmp_armed(cmp_armed)
    );

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    // One cycle: inputs applied on the falling edge, outputs read on the next falling edge.
    task automatic cyc(input logic [15:0] c, input logic lo, input logic hi,
                       input logic [7:0] d, input logic clr);
        tb_count = c; wr_lo = lo; wr_hi = hi; wr_data = d; flag_clr = clr;
        @(negedge clk);
        wr_lo = 1'b0; wr_hi = 1'b0; flag_clr = 1'b0; mode_wr = 1'b0;
    endtask

    task automatic set_mode(input logic t, input logic m, input logic ie, input logic [15:0] c);
        mode_tog = t; mode_mat = m; mode_ie = ie; mode_wr = 1'b1;
        cyc(c, 1'b0, 1'b0, 8'h00, 1'b0);
    endtask

    task automatic t_reset;
        chk("R1 tog_out", {15'd0, tog_out}, 16'd0);
        chk("R1 flag", {15'd0, match_flag}, 16'd0);
        chk("R1 irq", {15'd0, irq}, 16'd0);
        chk("R1 armed", {15'd0, cmp_armed}, 16'd0);
    endtask

    task automatic t_arm;
        cyc(16'h0100, 1'b1, 1'b0, 8'h34, 1'b0);
        chk("R2 lo write disarms", {15'd0, cmp_armed}, 16'd0);
        cyc(16'h0100, 1'b0, 1'b1, 8'h12, 1'b0);
        chk("R2 hi write arms", {15'd0, cmp_armed}, 16'd1);
    endtask

    task automatic t_toggle;
        set_mode(1'b1, 1'b1, 1'b1, 16'h0100);
        cyc(16'h1233, 1'b0, 1'b0, 8'h00, 1'b0);
        chk("R3 below value no toggle", {15'd0, tog_out}, 16'd0);
        cyc(16'h1234, 1'b0, 1'b0, 8'h00, 1'b0);
        chk("R3 match toggles", {15'd0, tog_out}, 16'd1);
        chk("R7 flag set", {15'd0, match_flag}, 16'd1);
        chk("R7 irq raised", {15'd0, irq}, 16'd1);
        cyc(16'h1235, 1'b0, 1'b0, 8'h00, 1'b0);
        chk("R3 past value holds", {15'd0, tog_out}, 16'd1);
        chk("R7 flag sticky", {15'd0, match_flag}, 16'd1);
        cyc(16'h1235, 1'b0, 1'b0, 8'h00, 1'b1);
        chk("R7 clear flag", {15'd0, match_flag}, 16'd0);
        chk("R7 irq drops", {15'd0, irq}, 16'd0);
    endtask

    task automatic t_stall;
        cyc(16'h1234, 1'b0, 1'b0, 8'h00, 1'b0);
        chk("R4 first equal cycle toggles", {15'd0, tog_out}, 16'd0);
        for (int i = 0; i < 4; i++) begin
            cyc(16'h1234, 1'b0, 1'b0, 8'h00, 1'b0);
            chk("R4 stalled count no retoggle", {15'd0, tog_out}, 16'd0);
        end
        cyc(16'h1000, 1'b0, 1'b0, 8'h00, 1'b1);
    endtask

    task automatic t_disarm;
        cyc(16'h1000, 1'b1, 1'b0, 8'h34, 1'b0);
        chk("R2 lo write disarms again", {15'd0, cmp_armed}, 16'd0);
        cyc(16'h1234, 1'b0, 1'b0, 8'h00, 1'b0);
        chk("R5 disarmed holds level", {15'd0, tog_out}, 16'd0);
        chk("R5 disarmed no flag", {15'd0, match_flag}, 16'd0);
        cyc(16'h1000, 1'b0, 1'b1, 8'h12, 1'b0);
        cyc(16'h1234, 1'b0, 1'b0, 8'h00, 1'b0);
        chk("R3 rearmed toggles", {15'd0, tog_out}, 16'd1);
        cyc(16'h1000, 1'b0, 1'b0, 8'h00, 1'b1);
    endtask

    task automatic t_notog;
        set_mode(1'b0, 1'b1, 1'b1, 16'h1000);
        cyc(16'h1234, 1'b0, 1'b0, 8'h00, 1'b0);
        chk("R6 flag without toggle", {15'd0, match_flag}, 16'd1);
        chk("R6 level unchanged", {15'd0, tog_out}, 16'd1);
        cyc(16'h1000, 1'b0, 1'b0, 8'h00, 1'b1);
    endtask

    task automatic t_noie;
        set_mode(1'b1, 1'b1, 1'b0, 16'h1000);
        cyc(16'h1234, 1'b0, 1'b0, 8'h00, 1'b0);
        chk("R10 new mode toggles", {15'd0, tog_out}, 16'd0);
        chk("R7 flag with ie=0", {15'd0, match_flag}, 16'd1);
        chk("R7 no irq with ie=0", {15'd0, irq}, 16'd0);
        cyc(16'h1000, 1'b0, 1'b0, 8'h00, 1'b1);
    endtask

    task automatic t_clr_race;
        set_mode(1'b1, 1'b1, 1'b1, 16'h1000);
        cyc(16'h1234, 1'b0, 1'b0, 8'h00, 1'b1);
        chk("R8 match beats clear", {15'd0, match_flag}, 16'd1);
        chk("R8 toggle still", {15'd0, tog_out}, 16'd1);
        cyc(16'h1000, 1'b0, 1'b0, 8'h00, 1'b1);
        chk("R8 later clear works", {15'd0, match_flag}, 16'd0);
    endtask

    task automatic t_wr_race;
        cyc(16'h1233, 1'b0, 1'b0, 8'h00, 1'b0);
        cyc(16'h1234, 1'b0, 1'b1, 8'h55, 1'b0);
        chk("R9 old value matched", {15'd0, tog_out}, 16'd0);
        chk("R9 flag from old value", {15'd0, match_flag}, 16'd1);
        cyc(16'h1000, 1'b0, 1'b0, 8'h00, 1'b1);
        cyc(16'h1234, 1'b0, 1'b0, 8'h00, 1'b0);
        chk("R9 old value gone", {15'd0, tog_out}, 16'd0);
        cyc(16'h5534, 1'b0, 1'b0, 8'h00, 1'b0);
        chk("R9 new value matches", {15'd0, tog_out}, 16'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_arm();
        t_toggle();
        t_stall();
        t_disarm();
        t_notog();
        t_noie();
        t_clr_race();
        t_wr_race();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 5000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule